// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is one output cell of a programmable logic array. The array hands it four sum terms. The cell turns them into a stored bit that can behave as a D flip-flop, a toggle flip-flop, a JK flip-flop or a transparent latch. The register type, the clock source, the clock polarity, the reset source, the preset source and the pad data source are all static configuration inputs. They are set once per cell and are expected to stay put while the cell runs.

The cell runs on a fast system clock. Its logical clock is a level: either sum term C or a shared global clock line, optionally inverted. A register update happens on the system clock edge that first sees that level go active. Reset and preset are level overrides that act on the registered output in the same cycle. Each one comes either from a sum term of the cell or from a shared global line.

Three functions leave the cell: the stored bit, a combinational copy of sum term A, and an output enable formed as the OR of a group of product terms. A pad data output carries either the stored bit or the combinational value, and the enable goes with it to the attached I/O.

Sum-term bit positions in `sum_t`: bit 0 is A (data, T or J), bit 1 is B (K, and the local preset), bit 2 is C (cell clock), bit 3 is D (local reset).

Top module: `lc_macrocell`

## Requirements
- R1: After `rst_n` is released with all inputs low, `reg_q` reads 0.
- R2: With `cfg_mode` = 2'b00 (D), an active clock edge loads sum term A into `reg_q`. The new value shows one system clock after the cycle in which the edge was presented.
- R3: With `cfg_mode` = 2'b01 (T), an active edge inverts `reg_q` when A is 1 and leaves it unchanged when A is 0.
- R4: With `cfg_mode` = 2'b10 (JK), A is J and B is K. On an active edge, JK=10 sets, 01 clears, 11 inverts and 00 holds.
- R5: With `cfg_mode` = 2'b11 (latch), `reg_q` follows A in the same cycle while the clock level is active. When the level goes inactive, it keeps the A value captured on the last system clock while open.
- R6: `cfg_clk_sel` = 0 takes the cell clock from sum term C, and 1 takes it from `glb_clk`. Activity on the unselected source leaves `reg_q` unchanged.
- R7: `cfg_clk_pol` = 0 makes the rising level change the active edge. A value of 1 makes the falling change active, with the latch open while the source is low.
- R8: `cfg_rst_sel` = 0 takes reset from sum term D, and 1 takes it from `glb_rst`. While the selected reset is high, `reg_q` is 0 in the same cycle, and it stays 0 after release until the next update. The unselected reset has no effect.
- R9: `cfg_pre_sel` = 0 takes preset from sum term B, and 1 takes it from `glb_pre`. While the selected preset is high, `reg_q` is 1 in the same cycle, and it stays 1 after release. The unselected preset has no effect.
- R10: When the selected reset and the selected preset are both high, `reg_q` is 0.
- R11: `comb_q` equals sum term A in the same cycle, in every mode and independent of `reg_q`.
- R12: `pad_oe` is the OR of all `oe_pt` bits. `pad_d` is `reg_q` when `cfg_pad_sel` = 0 and `comb_q` when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| sum_t | input | 4 | Sum terms A (bit 0), B (bit 1), C (bit 2), D (bit 3) |
| oe_pt | input | OE_PTS | Product terms ORed into the output enable |
| glb_clk | input | 1 | Global clock line |
| glb_rst | input | 1 | Global reset line |
| glb_pre | input | 1 | Global preset line |
| cfg_mode | input | 2 | 00 D, 01 T, 10 JK, 11 latch |
| cfg_clk_sel | input | 1 | 0 sum term C, 1 global clock |
| cfg_clk_pol | input | 1 | 0 active high/rising, 1 active low/falling |
| cfg_rst_sel | input | 1 | 0 sum term D, 1 global reset |
| cfg_pre_sel | input | 1 | 0 sum term B, 1 global preset |
| cfg_pad_sel | input | 1 | 0 pad carries stored bit, 1 pad carries combinational value |
| reg_q | output | 1 | Registered or latched output |
| comb_q | output | 1 | Combinational output (sum term A) |
| pad_d | output | 1 | Data toward the attached I/O |
| pad_oe | output | 1 | Output enable toward the attached I/O |

## Verification
An edge presented on the selected clock source is seen one system clock later: the stored bit changes on the edge that samples it. Reset, preset, the open latch, `comb_q`, `pad_d` and `pad_oe` all follow their inputs within the same cycle. The bench drives every input half a period before the sampling edge and pushes the expected outputs for that edge into a queue. The monitor pops them 1 ns after the edge, so registered and combinational results are compared at the same sample point. Configuration changes are applied just after a sample, which means the next update uses the new setting both in the design and in the model.

// File: rtl/lc_pkg.sv
package lc_pkg;

  localparam int NUM_SUM = 4;
  localparam int TERM_A  = 0;
  localparam int TERM_B  = 1;
  localparam int TERM_C  = 2;
  localparam int TERM_D  = 3;

  typedef enum logic [1:0] {
    MODE_D     = 2'b00,
    MODE_T     = 2'b01,
    MODE_JK    = 2'b10,
    MODE_LATCH = 2'b11
  } cell_mode_e;

  // Next stored value before reset/preset overrides are applied.
  function automatic logic lc_next(input cell_mode_e m, input logic cur,
                                   input logic a, input logic b,
                                   input logic edge_hit, input logic open_lvl);
    logic r;
    r = cur;
    case (m)
      MODE_D:  if (edge_hit) r = a;
      MODE_T:  if (edge_hit && a) r = ~cur;
      MODE_JK: begin
        if (edge_hit) begin
          case ({a, b})
            2'b10:   r = 1'b1;
            2'b01:   r = 1'b0;
            2'b11:   r = ~cur;
            default: r = cur;
          endcase
        end
      end
      default: if (open_lvl) r = a;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lc_clk_pick.sv
module lc_clk_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_src,
  input  logic glb_src,
  input  logic sel_glb,
  input  logic inv_pol,
  output logic act_lvl,
  output logic act_edge
);

  logic lvl_prev;

  assign act_lvl = (sel_glb ? glb_src : cell_src) ^ inv_pol;

  // Seeded high so a level already active at release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b1;
    else        lvl_prev <= act_lvl;
  end

  assign act_edge = act_lvl & ~lvl_prev;

endmodule

// File: rtl/lc_async_ctl.sv
module lc_async_ctl (
  input  logic loc_rst,
  input  logic glb_rst,
  input  logic rst_sel,
  input  logic loc_pre,
  input  logic glb_pre,
  input  logic pre_sel,
  output logic clr_act,
  output logic set_act
);

  logic rst_src, pre_src;

  assign rst_src = rst_sel ? glb_rst : loc_rst;
  assign pre_src = pre_sel ? glb_pre : loc_pre;
  assign clr_act = rst_src;
  assign set_act = pre_src & ~rst_src;

endmodule

// File: rtl/lc_oe_sum.sv
module lc_oe_sum #(
  parameter int N_PT = 4
) (
  input  logic [N_PT-1:0] pt,
  output logic            oe
);

  logic [N_PT:0] acc;

  assign acc[0] = 1'b0;
  for (genvar g = 0; g < N_PT; g++) begin : g_or
    assign acc[g+1] = acc[g] | pt[g];
  end
  assign oe = acc[N_PT];

endmodule

// File: rtl/lc_store.sv
module lc_store
  import lc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cell_mode_e mode,
  input  logic       d_a,
  input  logic       d_b,
  input  logic       edge_hit,
  input  logic       open_lvl,
  input  logic       clr_act,
  input  logic       set_act,
  output logic       q
);

  logic state, nxt;

  always_comb begin
    nxt = lc_next(mode, state, d_a, d_b, edge_hit, open_lvl);
    if (clr_act)      nxt = 1'b0;
    else if (set_act) nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= 1'b0;
    else        state <= nxt;
  end

  always_comb begin
    if (clr_act)                             q = 1'b0;
    else if (set_act)                        q = 1'b1;
    else if (mode == MODE_LATCH && open_lvl) q = d_a;
    else                                     q = state;
  end

endmodule

// File: rtl/lc_macrocell.sv
module lc_macrocell
  import lc_pkg::*;
#(
  parameter int OE_PTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SUM-1:0] sum_t,
  input  logic [OE_PTS-1:0]  oe_pt,
  input  logic               glb_clk,
  input  logic               glb_rst,
  input  logic               glb_pre,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_clk_sel,
  input  logic               cfg_clk_pol,
  input  logic               cfg_rst_sel,
  input  logic               cfg_pre_sel,
  input  logic               cfg_pad_sel,
  output logic               reg_q,
  output logic               comb_q,
  output logic               pad_d,
  output logic               pad_oe
);

  cell_mode_e mode;
  logic gate_open, cell_edge, clr_act, set_act, oe_sum;

  assign mode = cell_mode_e'(cfg_mode);

  lc_clk_pick u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cell_src (sum_t[TERM_C]),
    .glb_src  (glb_clk),
    .sel_glb  (cfg_clk_sel),
    .inv_pol  (cfg_clk_pol),
    .act_lvl  (gate_open),
    .act_edge (cell_edge)
  );

  lc_async_ctl u_ovr (
    .loc_rst (sum_t[TERM_D]),
    .glb_rst (glb_rst),
    .rst_sel (cfg_rst_sel),
    .loc_pre (sum_t[TERM_B]),
    .glb_pre (glb_pre),
    .pre_sel (cfg_pre_sel),
    .clr_act (clr_act),
    .set_act (set_act)
  );

  lc_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .d_a      (sum_t[TERM_A]),
    .d_b      (sum_t[TERM_B]),
    .edge_hit (cell_edge),
    .open_lvl (gate_open),
    .clr_act  (clr_act),
    .set_act  (set_act),
    .q        (reg_q)
  );

  lc_oe_sum #(.N_PT(OE_PTS)) u_oe (
    .pt (oe_pt),
    .oe (oe_sum)
  );

  assign comb_q = sum_t[TERM_A];
  assign pad_d  = cfg_pad_sel ? comb_q : reg_q;
  assign pad_oe = oe_sum;

endmodule

// File: rtl/lc_macrocell_chk.sv
module lc_macrocell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       term_a,
  input logic       loc_rst,
  input logic       loc_pre,
  input logic       cfg_rst_sel,
  input logic       cfg_pre_sel,
  input logic       glb_rst,
  input logic       glb_pre,
  input logic       cell_edge,
  input logic       gate_open,
  input logic       clr_act,
  input logic       set_act,
  input logic       reg_q
);

  logic rst_port, pre_port, busy;

  assign rst_port = cfg_rst_sel ? glb_rst : loc_rst;
  assign pre_port = cfg_pre_sel ? glb_pre : loc_pre;
  assign busy     = clr_act || set_act || (cfg_mode == 2'b11 && gate_open);

  assert_reset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_port |-> !reg_q);

  assert_preset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_port && !rst_port) |-> reg_q);

  assert_d_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b00 && cell_edge && !clr_act && !set_act)
    |=> (busy || reg_q == $past(term_a)));

  assert_t_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b01 && cell_edge && !clr_act && !set_act)
    |=> (busy || reg_q == ($past(reg_q) ^ $past(term_a))));

  assert_no_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'b11 && !cell_edge && !clr_act && !set_act)
    |=> (busy || $stable(reg_q)));

endmodule

bind lc_macrocell lc_macrocell_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_mode    (cfg_mode),
  .term_a      (sum_t[0]),
  .loc_rst     (sum_t[3]),
  .loc_pre     (sum_t[1]),
  .cfg_rst_sel (cfg_rst_sel),
  .cfg_pre_sel (cfg_pre_sel),
  .glb_rst     (glb_rst),
  .glb_pre     (glb_pre),
  .cell_edge   (cell_edge),
  .gate_open   (gate_open),
  .clr_act     (clr_act),
  .set_act     (set_act),
  .reg_q       (reg_q)
);

// File: tb/lc_macrocell_tb.sv
`timescale 1ns/1ps
module lc_macrocell_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sum_t = 4'b0;
  logic [3:0] oe_pt = 4'b0;
  logic       glb_clk = 1'b0, glb_rst = 1'b0, glb_pre = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_clk_sel = 1'b0, cfg_clk_pol = 1'b0;
  logic       cfg_rst_sel = 1'b0, cfg_pre_sel = 1'b0, cfg_pad_sel = 1'b0;
  logic       reg_q, comb_q, pad_d, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lc_macrocell #(.OE_PTS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .sum_t(sum_t), .oe_pt(oe_pt),
    .glb_clk(glb_clk), .glb_rst(glb_rst), .glb_pre(glb_pre),
    .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel), .cfg_clk_pol(cfg_clk_pol),
    .cfg_rst_sel(cfg_rst_sel), .cfg_pre_sel(cfg_pre_sel), .cfg_pad_sel(cfg_pad_sel),
    .reg_q(reg_q), .comb_q(comb_q), .pad_d(pad_d), .pad_oe(pad_oe)
  );

  typedef struct {
    logic  rq, cq, pd, oe;
    string tag;
  } exp_t;
  exp_t sb[$];

  // Bench model of the stored bit and the last sampled clock level.
  logic m_q = 1'b0;
  logic m_prev = 1'b1;

  task automatic drive(input logic [3:0] t, input logic gc, input logic gr,
                       input logic gp, input string tag);
    exp_t e;
    logic lvl, hit, rs, ps, a, b;
    @(negedge clk);
    sum_t = t; glb_clk = gc; glb_rst = gr; glb_pre = gp;
    a   = t[0];
    b   = t[1];
    lvl = cfg_clk_pol ? ~(cfg_clk_sel ? gc : t[2]) : (cfg_clk_sel ? gc : t[2]);
    hit = lvl && !m_prev;
    rs  = cfg_rst_sel ? gr : t[3];
    ps  = cfg_pre_sel ? gp : t[1];
    if (rs)      m_q = 1'b0;
    else if (ps) m_q = 1'b1;
    else if (cfg_mode == 2'b11) begin
      if (lvl) m_q = a;
    end else if (hit) begin
      if (cfg_mode == 2'b00) m_q = a;
      else if (cfg_mode == 2'b01) m_q = m_q ^ a;
      else if (a && !b) m_q = 1'b1;
      else if (!a && b) m_q = 1'b0;
      else if (a && b) m_q = ~m_q;
    end
    m_prev = lvl;
    e.rq  = m_q;
    e.cq  = a;
    e.pd  = cfg_pad_sel ? a : m_q;
    e.oe  = (oe_pt != 4'b0);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic cs, input logic cp,
                         input logic rsel, input logic psel, input logic pdsel,
                         input logic [3:0] oe);
    @(posedge clk);
    #2;
    cfg_mode = m; cfg_clk_sel = cs; cfg_clk_pol = cp;
    cfg_rst_sel = rsel; cfg_pre_sel = psel; cfg_pad_sel = pdsel; oe_pt = oe;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (reg_q !== e.rq || comb_q !== e.cq || pad_d !== e.pd || pad_oe !== e.oe) begin
          errors++;
          $display("FAIL %s: reg_q=%b comb_q=%b pad_d=%b pad_oe=%b expected %b %b %b %b",
                   e.tag, reg_q, comb_q, pad_d, pad_oe, e.rq, e.cq, e.pd, e.oe);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    drive(4'b0000, 0, 0, 0, "R1");
    drive(4'b0000, 0, 0, 0, "R1");
    // R2: D capture on term C rising
    drive(4'b0001, 0, 0, 0, "R2");
    drive(4'b0101, 0, 0, 0, "R2");
    drive(4'b0100, 0, 0, 0, "R2");
    drive(4'b0000, 0, 0, 0, "R2");
    drive(4'b0100, 0, 0, 0, "R2");
    drive(4'b0001, 0, 0, 0, "R2");
    // R11 / R12: combinational path, pad select, OE sum
    set_cfg(2'b00, 0, 0, 0, 0, 1, 4'b0100);
    drive(4'b0001, 0, 0, 0, "R11");
    drive(4'b0000, 0, 0, 0, "R12");
    for (int i = 0; i < 4; i++) begin
      set_cfg(2'b00, 0, 0, 0, 0, i[0], 4'(1 << i) & {4{i[1]}});
      drive({3'b000, ~i[0]}, 0, 0, 0, "R12");
    end
    set_cfg(2'b00, 0, 0, 0, 0, 0, 4'b0000);
    drive(4'b0001, 0, 0, 0, "R11");
    // R3: toggle mode
    set_cfg(2'b01, 0, 0, 0, 0, 0, 4'b0000);
    for (int i = 0; i < 3; i++) begin
      drive(4'b0001, 0, 0, 0, "R3");
      drive(4'b0101, 0, 0, 0, "R3");
    end
    for (int i = 0; i < 2; i++) begin
      drive(4'b0000, 0, 0, 0, "R3");
      drive(4'b0100, 0, 0, 0, "R3");
    end
    // R4: JK, preset taken from the global line so B is free
    set_cfg(2'b10, 0, 0, 0, 1, 0, 4'b0000);
    begin
      logic [1:0] jk [6] = '{2'b10, 2'b00, 2'b01, 2'b11, 2'b11, 2'b10};
      for (int i = 0; i < 6; i++) begin
        drive({2'b00, jk[i][0], jk[i][1]}, 0, 0, 0, "R4");
        drive({2'b01, jk[i][0], jk[i][1]}, 0, 0, 0, "R4");
      end
    end
    // R5: transparent latch
    set_cfg(2'b11, 0, 0, 0, 1, 0, 4'b0000);
    drive(4'b0101, 0, 0, 0, "R5");
    drive(4'b0100, 0, 0, 0, "R5");
    drive(4'b0101, 0, 0, 0, "R5");
    drive(4'b0000, 0, 0, 0, "R5");
    drive(4'b0001, 0, 0, 0, "R5");
    drive(4'b0000, 0, 0, 0, "R5");
    // R6: global clock selected, term C ignored
    set_cfg(2'b00, 1, 0, 0, 0, 0, 4'b0000);
    drive(4'b0000, 0, 0, 0, "R6");
    drive(4'b0000, 1, 0, 0, "R6");
    drive(4'b0001, 0, 0, 0, "R6");
    drive(4'b0101, 0, 0, 0, "R6");
    drive(4'b0001, 0, 0, 0, "R6");
    drive(4'b0101, 0, 0, 0, "R6");
    drive(4'b0001, 1, 0, 0, "R6");
    // R7: falling polarity on term C
    set_cfg(2'b00, 0, 1, 0, 0, 0, 4'b0000);
    drive(4'b0100, 0, 0, 0, "R7");
    drive(4'b0000, 0, 0, 0, "R7");
    drive(4'b0101, 0, 0, 0, "R7");
    drive(4'b0001, 0, 0, 0, "R7");
    drive(4'b0101, 0, 0, 0, "R7");
    // R8: local then global reset
    set_cfg(2'b00, 0, 0, 0, 0, 0, 4'b0000);
    drive(4'b1001, 0, 0, 0, "R8");
    drive(4'b0001, 0, 0, 0, "R8");
    drive(4'b0101, 0, 0, 0, "R8");
    set_cfg(2'b00, 0, 0, 1, 0, 0, 4'b0000);
    drive(4'b1001, 0, 0, 0, "R8");
    drive(4'b0001, 0, 1, 0, "R8");
    drive(4'b0001, 0, 0, 0, "R8");
    // R9: local then global preset
    set_cfg(2'b00, 0, 0, 0, 0, 0, 4'b0000);
    drive(4'b0010, 0, 0, 0, "R9");
    drive(4'b0000, 0, 0, 0, "R9");
    drive(4'b1000, 0, 0, 0, "R9");
    set_cfg(2'b00, 0, 0, 0, 1, 0, 4'b0000);
    drive(4'b0010, 0, 0, 0, "R9");
    drive(4'b0000, 0, 0, 1, "R9");
    drive(4'b0000, 0, 0, 0, "R9");
    // R10: reset beats preset
    set_cfg(2'b00, 0, 0, 0, 0, 0, 4'b0000);
    drive(4'b1010, 0, 0, 0, "R10");
    set_cfg(2'b00, 0, 0, 1, 1, 0, 4'b0000);
    drive(4'b0000, 0, 1, 1, "R10");
    drive(4'b0000, 0, 0, 1, "R10");
    drive(4'b0000, 0, 1, 1, "R10");
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule